// File: doc/BRIEF.md
# Interrupt Event Coalescing State Controller

This block keeps a two-bit coalescing state for each of a parameterized number of interrupt sources. The high bit (P) records that an event has been sent onward and is waiting for its end-of-interrupt. The low bit (Q) records that another event arrived while P was set. Together they ensure a source is handed to the rest of the interrupt system at most once until software acknowledges it.

Software and the event fabric reach the states through a simple load/store port. Each source owns one page of address space, and the page size is set by a shift parameter. A store at page offset zero is a trigger. Loads at fixed offsets inside the page acknowledge, query, or overwrite the state, and each load returns the state held before it in a single atomic cycle. A trigger that takes a source from idle to pending raises a one-cycle notification that carries the source index, unless that source is masked.

Top module: `irq_pq_ctrl`

## Requirements
- R1: After reset every source state is 00, and `rsp_valid` and `notify` are low.
- R2: A store at page offset 0 changes the state as follows: 00 goes to 10, 10 goes to 11, 11 stays 11, and 01 stays 01.
- R3: `notify` pulses for one cycle, in the cycle after the store, only when a trigger takes an unmasked source from 00 to 10, and `notify_idx` gives that source.
- R4: While `src_mask` is set for a source, a trigger still changes that source's state as in R2 but never raises `notify`.
- R5: A load at offset 0x000 is an end-of-interrupt. It takes 10 to 00 and returns 0. It leaves 00 unchanged and returns 0. It takes 11 to 10 and returns 1. It leaves 01 unchanged and returns 0.
- R6: A load at offset 0x800 returns the current state and does not change it.
- R7: A load at offset 0xC00, 0xD00, 0xE00 or 0xF00 writes address bits [9:8] as the new state and returns the state held before the write.
- R8: A load returns all ones and changes nothing in any of these cases: the source index is at or above NUM_SRC, the source's `src_valid` is low, `req_size` is not 8, or the page offset is not one of those listed in R5 to R7.
- R9: A store at a nonzero page offset, to an out-of-range or invalid source, or with `req_size` not 8 changes no state and raises no `notify`.
- R10: Every load gets `rsp_valid` in the next cycle and stores get none. The returned state is zero-extended in the low bits of the 64-bit word, and an access in the next cycle already sees the updated state.
- R11: The source index is the address shifted right by PAGE_SHIFT and the page offset is address bits [11:8]. An access changes only the addressed source, including neighbours that share a storage byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store (trigger page), 0 = load |
| req_addr | input | ADDR_W | Byte address: source index above PAGE_SHIFT, offset in [11:8] |
| req_size | input | 4 | Access width in bytes; only 8 is accepted |
| src_valid | input | NUM_SRC | Per-source enable; invalid sources reject accesses |
| src_mask | input | NUM_SRC | Per-source notification mask |
| rsp_valid | output | 1 | Load data valid, one cycle after the load |
| rsp_data | output | 64 | Previous state, end-of-interrupt flag, or all ones |
| notify | output | 1 | One-cycle notification pulse |
| notify_idx | output | IDX_W | Source index of the notification |

## Verification
A corrupted state bit shows up at the ports on the next access to that source. A query load returns the wrong value one cycle later, and a trigger either produces a spurious `notify` or drops one in the cycle after the store. The table walks one source through every trigger, acknowledge and force transition, with a query after each change. This exposes a wrong state within two accesses. Corruption of a neighbour that shares a storage byte is caught by queries to the adjacent indices after a trigger.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

    typedef logic [1:0] pq_t;

    localparam pq_t PQ_IDLE = 2'b00;
    localparam pq_t PQ_PEND = 2'b10;
    localparam pq_t PQ_QUED = 2'b11;
    localparam pq_t PQ_OFF  = 2'b01;

    localparam logic [3:0] OFS_ACK   = 4'h0;
    localparam logic [3:0] OFS_QUERY = 4'h8;
    localparam logic [3:0] OFS_FIRE  = 4'h0;
    localparam logic [3:0] ACCESS_BYTES = 4'd8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ACK,
        OP_QUERY,
        OP_FORCE,
        OP_FIRE,
        OP_REJECT
    } op_e;

    function automatic pq_t pq_after_fire(input pq_t cur);
        case (cur)
            PQ_IDLE: return PQ_PEND;
            PQ_PEND: return PQ_QUED;
            PQ_QUED: return PQ_QUED;
            default: return PQ_OFF;
        endcase
    endfunction

    function automatic pq_t pq_after_ack(input pq_t cur);
        case (cur)
            PQ_PEND: return PQ_IDLE;
            PQ_QUED: return PQ_PEND;
            PQ_OFF:  return PQ_OFF;
            default: return PQ_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/irq_pq_decode.sv
module irq_pq_decode
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC    = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int ADDR_W     = 17,
    parameter int IDX_W      = 4
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3:0]          req_size,
    input  logic [NUM_SRC-1:0]  src_valid,
    output op_e                 op,
    output logic [IDX_W-1:0]    idx,
    output pq_t                 force_pq
);
    localparam int FULL_W = ADDR_W - PAGE_SHIFT;

    logic [FULL_W-1:0] full_idx;
    logic [3:0]        page_ofs;
    logic              in_range;
    logic              src_ok;
    logic              size_ok;
    logic              unused_low_bits;

    assign full_idx = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign page_ofs = req_addr[11:8];
    assign idx      = full_idx[IDX_W-1:0];
    assign in_range = (32'(full_idx) < NUM_SRC);
    assign src_ok   = in_range && src_valid[idx];
    assign size_ok  = (req_size == ACCESS_BYTES);
    assign force_pq = req_addr[9:8];
    assign unused_low_bits = ^{req_addr[7:0], req_addr[PAGE_SHIFT-1:8]};

    always_comb begin
        op = OP_NONE;
        if (req_valid) begin
            if (req_write) begin
                if (src_ok && size_ok && page_ofs == OFS_FIRE) begin
                    op = OP_FIRE;
                end
            end else if (!src_ok || !size_ok) begin
                op = OP_REJECT;
            end else begin
                case (page_ofs)
                    OFS_ACK:                   op = OP_ACK;
                    OFS_QUERY:                 op = OP_QUERY;
                    4'hC, 4'hD, 4'hE, 4'hF:    op = OP_FORCE;
                    default:                   op = OP_REJECT;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_pq_store.sv
module irq_pq_store
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output pq_t              rd_pq,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pq_t              wr_pq
);
    localparam int NBYTES = (NUM_SRC + 3) / 4;
    localparam int BSEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [7:0] pack_d [NBYTES];
    logic [7:0] pack_q [NBYTES];

    logic [BSEL_W-1:0] rd_byte;
    logic [BSEL_W-1:0] wr_byte;
    logic [2:0]        rd_bit;
    logic [2:0]        wr_bit;

    assign rd_byte = BSEL_W'(rd_idx >> 2);
    assign wr_byte = BSEL_W'(wr_idx >> 2);
    assign rd_bit  = {rd_idx[1:0], 1'b0};
    assign wr_bit  = {wr_idx[1:0], 1'b0};

    assign rd_pq = pack_q[rd_byte][rd_bit +: 2];

    always_comb begin
        for (int b = 0; b < NBYTES; b++) begin
            pack_d[b] = pack_q[b];
        end
        if (wr_en) begin
            pack_d[wr_byte][wr_bit +: 2] = wr_pq;
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pack_q[g] <= '0;
            end else begin
                pack_q[g] <= pack_d[g];
            end
        end
    end

endmodule

// File: rtl/irq_pq_ctrl.sv
module irq_pq_ctrl
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC    = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int ADDR_W     = 17,
    parameter int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [3:0]         req_size,
    input  logic [NUM_SRC-1:0] src_valid,
    input  logic [NUM_SRC-1:0] src_mask,
    output logic               rsp_valid,
    output logic [63:0]        rsp_data,
    output logic               notify,
    output logic [IDX_W-1:0]   notify_idx
);
    typedef struct packed {
        logic             rsp_vld;
        logic [63:0]      rsp_data;
        logic             ntf;
        logic [IDX_W-1:0] ntf_idx;
    } out_s;

    out_s out_d, out_q;

    op_e              op;
    logic [IDX_W-1:0] idx;
    pq_t              force_pq;
    pq_t              cur_pq;
    logic             wr_en;
    pq_t              wr_pq;

    irq_pq_decode #(
        .NUM_SRC   (NUM_SRC),
        .PAGE_SHIFT(PAGE_SHIFT),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) u_decode (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_size (req_size),
        .src_valid(src_valid),
        .op       (op),
        .idx      (idx),
        .force_pq (force_pq)
    );

    irq_pq_store #(
        .NUM_SRC(NUM_SRC),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(idx),
        .rd_pq (cur_pq),
        .wr_en (wr_en),
        .wr_idx(idx),
        .wr_pq (wr_pq)
    );

    always_comb begin
        out_d          = out_q;
        out_d.rsp_vld  = req_valid && !req_write;
        out_d.rsp_data = '0;
        out_d.ntf      = 1'b0;
        wr_en          = 1'b0;
        wr_pq          = cur_pq;
        case (op)
            OP_ACK: begin
                wr_en          = 1'b1;
                wr_pq          = pq_after_ack(cur_pq);
                out_d.rsp_data = {63'd0, cur_pq == PQ_QUED};
            end
            OP_QUERY: begin
                out_d.rsp_data = {62'd0, cur_pq};
            end
            OP_FORCE: begin
                wr_en          = 1'b1;
                wr_pq          = force_pq;
                out_d.rsp_data = {62'd0, cur_pq};
            end
            OP_FIRE: begin
                wr_en = 1'b1;
                wr_pq = pq_after_fire(cur_pq);
                if (cur_pq == PQ_IDLE && !src_mask[idx]) begin
                    out_d.ntf     = 1'b1;
                    out_d.ntf_idx = idx;
                end
            end
            OP_REJECT: begin
                out_d.rsp_data = '1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rsp_valid  = out_q.rsp_vld;
    assign rsp_data   = out_q.rsp_data;
    assign notify     = out_q.ntf;
    assign notify_idx = out_q.ntf_idx;

endmodule

// File: rtl/irq_pq_ctrl_chk.sv
module irq_pq_ctrl_chk #(
    parameter int NUM_SRC    = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int ADDR_W     = 17,
    parameter int IDX_W      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [3:0]         req_size,
    input logic [NUM_SRC-1:0] src_mask,
    input logic               rsp_valid,
    input logic [63:0]        rsp_data,
    input logic               notify,
    input logic [IDX_W-1:0]   notify_idx
);
    localparam int FULL_W = ADDR_W - PAGE_SHIFT;

    logic [FULL_W-1:0] a_full;
    logic [IDX_W-1:0]  a_idx;
    logic              a_in_range;
    logic              unused_size;

    assign a_full      = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign a_idx       = a_full[IDX_W-1:0];
    assign a_in_range  = (32'(a_full) < NUM_SRC);
    assign unused_size = ^req_size;

    AST_LOAD_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);                         // R10

    AST_NO_RSP_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);                       // R10

    AST_NOTIFY_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> !notify);                           // R3

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && a_in_range && src_mask[a_idx]) |=> !notify); // R4

    AST_NOTIFY_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> notify_idx == $past(a_idx));                           // R11

    AST_RSP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data[63:2] == '0 || rsp_data == '1));          // R8

endmodule

bind irq_pq_ctrl irq_pq_ctrl_chk #(
    .NUM_SRC   (NUM_SRC),
    .PAGE_SHIFT(PAGE_SHIFT),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .src_mask  (src_mask),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .notify    (notify),
    .notify_idx(notify_idx)
);

// File: tb/irq_pq_ctrl_test.sv
module irq_pq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC    = 16;
    localparam int PAGE_SHIFT = 12;
    localparam int ADDR_W     = 17;
    localparam int IDX_W      = 4;
    localparam logic [63:0] ONES = '1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [3:0]         req_size = 4'd8;
    logic [NUM_SRC-1:0] src_valid = '1;
    logic [NUM_SRC-1:0] src_mask = '0;
    logic               rsp_valid;
    logic [63:0]        rsp_data;
    logic               notify;
    logic [IDX_W-1:0]   notify_idx;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_pq_ctrl #(
        .NUM_SRC   (NUM_SRC),
        .PAGE_SHIFT(PAGE_SHIFT),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .src_valid (src_valid),
        .src_mask  (src_mask),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .notify    (notify),
        .notify_idx(notify_idx)
    );

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [63:0] exp;
        logic        ntf;
        logic [3:0]  nidx;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 17'h03800, 64'd0, 1'b0, 4'd0},  // R1 state 00 after reset
        '{1'b1, 17'h03000, 64'd0, 1'b1, 4'd3},  // R2 R3 00->10 notifies
        '{1'b0, 17'h03800, 64'd2, 1'b0, 4'd0},  // R6 query 10
        '{1'b1, 17'h03000, 64'd0, 1'b0, 4'd0},  // R2 10->11 silent
        '{1'b0, 17'h03800, 64'd3, 1'b0, 4'd0},  // R6
        '{1'b1, 17'h03000, 64'd0, 1'b0, 4'd0},  // R2 11 stays
        '{1'b0, 17'h03800, 64'd3, 1'b0, 4'd0},  // R6
        '{1'b0, 17'h03000, 64'd1, 1'b0, 4'd0},  // R5 11->10 returns 1
        '{1'b0, 17'h03000, 64'd0, 1'b0, 4'd0},  // R5 10->00 returns 0
        '{1'b0, 17'h03000, 64'd0, 1'b0, 4'd0},  // R5 00 stays, 0
        '{1'b0, 17'h03D00, 64'd0, 1'b0, 4'd0},  // R7 force 01, old 00
        '{1'b1, 17'h03000, 64'd0, 1'b0, 4'd0},  // R2 off stays, no pulse
        '{1'b0, 17'h03000, 64'd0, 1'b0, 4'd0},  // R5 off ack returns 0
        '{1'b0, 17'h03800, 64'd1, 1'b0, 4'd0},  // R6 still 01
        '{1'b0, 17'h03F00, 64'd1, 1'b0, 4'd0},  // R7 force 11, old 01
        '{1'b0, 17'h03E00, 64'd3, 1'b0, 4'd0},  // R7 force 10, old 11
        '{1'b0, 17'h03C00, 64'd2, 1'b0, 4'd0},  // R7 force 00, old 10
        '{1'b0, 17'h03900, ONES,  1'b0, 4'd0},  // R8 unknown offset
        '{1'b0, 17'h03800, 64'd0, 1'b0, 4'd0},  // R8 no change
        '{1'b1, 17'h03800, 64'd0, 1'b0, 4'd0},  // R9 store nonzero offset
        '{1'b0, 17'h03800, 64'd0, 1'b0, 4'd0},  // R9 no change
        '{1'b1, 17'h05000, 64'd0, 1'b1, 4'd5},  // R11 source 5 fires
        '{1'b0, 17'h04800, 64'd0, 1'b0, 4'd0},  // R11 neighbour 4 untouched
        '{1'b0, 17'h06800, 64'd0, 1'b0, 4'd0},  // R11 neighbour 6 untouched
        '{1'b0, 17'h05800, 64'd2, 1'b0, 4'd0},  // R11 source 5 pending
        '{1'b0, 17'h10800, ONES,  1'b0, 4'd0},  // R8 index out of range
        '{1'b1, 17'h1F000, 64'd0, 1'b0, 4'd0}   // R9 store out of range
    };

    logic        s_vld;
    logic [63:0] s_data;
    logic        s_ntf;
    logic [3:0]  s_idx;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge, leave the
    // request on the bus so the next call runs back to back.
    task automatic xfer(input logic wr, input logic [16:0] addr, input logic [3:0] sz);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = sz;
        @(negedge clk);
        s_vld  = rsp_valid;
        s_data = rsp_data;
        s_ntf  = notify;
        s_idx  = notify_idx;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        req_write = 1'b0;
        req_size  = 4'd8;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        chk("R1 notify in reset", {63'd0, notify}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk (R2 R3 R5 R6 R7 R8 R9 R10 R11)
        for (int k = 0; k < NV; k++) begin
            xfer(VECS[k].wr, VECS[k].addr, 4'd8);
            chk($sformatf("R10 vec %0d rsp_valid", k), {63'd0, s_vld}, {63'd0, !VECS[k].wr});
            if (!VECS[k].wr) chk($sformatf("R5-7 vec %0d data (R6)", k), s_data, VECS[k].exp);
            chk($sformatf("R3 vec %0d notify", k), {63'd0, s_ntf}, {63'd0, VECS[k].ntf});
            if (VECS[k].ntf) chk($sformatf("R11 vec %0d notify_idx", k), {60'd0, s_idx}, {60'd0, VECS[k].nidx});
        end
        idle();

        // R4: masked source still advances, no pulse
        src_mask[7] = 1'b1;
        xfer(1'b1, 17'h07000, 4'd8);
        chk("R4 masked trigger notify", {63'd0, s_ntf}, 64'd0);
        xfer(1'b0, 17'h07800, 4'd8);
        chk("R4 masked state advanced", s_data, 64'd2);
        xfer(1'b0, 17'h07000, 4'd8);
        chk("R4 ack returns 0", s_data, 64'd0);
        src_mask[7] = 1'b0;
        xfer(1'b1, 17'h07000, 4'd8);
        chk("R4 unmasked notify", {63'd0, s_ntf}, 64'd1);
        idle();

        // R8 R9: invalid source
        src_valid[9] = 1'b0;
        xfer(1'b1, 17'h09000, 4'd8);
        chk("R9 invalid source store notify", {63'd0, s_ntf}, 64'd0);
        xfer(1'b0, 17'h09800, 4'd8);
        chk("R8 invalid source load", s_data, ONES);
        xfer(1'b0, 17'h09F00, 4'd8);
        chk("R8 invalid source force", s_data, ONES);
        src_valid[9] = 1'b1;
        xfer(1'b0, 17'h09800, 4'd8);
        chk("R9 invalid source unchanged", s_data, 64'd0);

        // R8 R9: wrong access size
        xfer(1'b1, 17'h0A000, 4'd4);
        chk("R9 short store notify", {63'd0, s_ntf}, 64'd0);
        xfer(1'b0, 17'h0AF00, 4'd4);
        chk("R8 short load data", s_data, ONES);
        xfer(1'b0, 17'h0A800, 4'd8);
        chk("R8 short accesses changed nothing", s_data, 64'd0);

        // R10: back-to-back trigger then query sees new state
        xfer(1'b1, 17'h0B000, 4'd8);
        chk("R3 back-to-back notify", {63'd0, s_ntf}, 64'd1);
        xfer(1'b0, 17'h0B800, 4'd8);
        chk("R10 back-to-back query", s_data, 64'd2);
        idle();
        chk("R10 no rsp when idle", {63'd0, rsp_valid}, 64'd0);

        // R1: reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        xfer(1'b0, 17'h0B800, 4'd8);
        chk("R1 state cleared by reset", s_data, 64'd0);
        xfer(1'b0, 17'h03800, 4'd8);
        chk("R1 source 3 cleared", s_data, 64'd0);
        idle();

        finished = 1;
        finish_run();
    end

endmodule